// File: doc/BRIEF.md
# Register Region Access Decoder

This block is the front end of a memory-mapped register space. A requester presents an absolute address, an access size (1, 2, 4 or 8 bytes), a read/write flag and write data in little-endian byte order. The block subtracts the device base address, finds which entry of a fixed, sorted region table holds the offset, and checks the access size and alignment against that region's permitted widths.

Legal accesses are passed to a handler port in the same cycle. The port carries the region index, the offset within the region and the write data converted to native (right-aligned) order. For reads, the handler's data is converted back into bus order. Some regions have built-in behaviour: they read as zero, read as all ones, or ignore writes.

Accesses that miss every region, or that break the width rules, never reach a handler. Reads of this kind return zero, and every request completes with a response one cycle later.

Top module: `regacc_decoder`

## Requirements
- R1: The offset is the request address minus DEV_BASE (default 0x1000), with wrap-around. Region i is selected when base_i <= offset < base_i + span_i. The default table, as index:base/span in hex, is 0:00/10, 1:10/10, 2:40/20, 3:80/40. For an access that is passed on, hdl_idx equals the region index and hdl_off equals offset minus base.
- R2: Size code 0 (1 byte) is legal only in regions whose byte-access flag is set. The flag is set in regions 0 and 2 and clear in regions 1 and 3. No alignment applies.
- R3: Size code 2 (4 bytes) is legal only in regions with the word flag set (regions 0, 1 and 2) and only when address bits 1:0 are zero.
- R4: Size code 3 (8 bytes) is legal only in regions with the doubleword flag set (regions 0 and 3) and only when address bits 2:0 are zero.
- R5: Size code 1 (2 bytes) is never legal in any region.
- R6: A read that misses every region or is not legal raises no handler strobe. It returns rsp_rdata of zero.
- R7: A write that misses every region or is not legal raises no handler strobe. It still completes with a response.
- R8: On the bus, the first byte of a transfer sits in bits 63:56, the next in bits 55:48, and so on. For a legal write to a handler region, hdl_wr_en is high in the request cycle. Bus byte k then appears at hdl_wdata bits 8k+7:8k for k below the access length, and the bits above are zero.
- R9: For a legal read from a handler region, hdl_rd_en is high in the request cycle. Byte k of hdl_rdata is returned in bus bits (63-8k):(56-8k), and bus lanes beyond the access length are zero.
- R10: Region 1 reads as zero. A legal read there returns zero and raises no hdl_rd_en.
- R11: Region 2 reads as all ones. A legal read there returns 0xFF in each of the bus lanes the access covers, and raises no hdl_rd_en.
- R12: Regions 1 and 3 ignore writes. A legal write there raises no hdl_wr_en.
- R13: rsp_valid is high in exactly the cycle after each request and low otherwise. For writes, rsp_rdata is zero. Reset clears rsp_valid and rsp_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Absolute byte address |
| req_size | input | 2 | Size code: 0=1B, 1=2B, 2=4B, 3=8B |
| req_wdata | input | 64 | Write data, bus byte order |
| rsp_valid | output | 1 | Response, one cycle after the request |
| rsp_rdata | output | 64 | Read data, bus byte order |
| hdl_rd_en | output | 1 | Handler read strobe |
| hdl_wr_en | output | 1 | Handler write strobe |
| hdl_idx | output | IDX_W | Selected region index |
| hdl_off | output | ADDR_W | Offset within the selected region |
| hdl_size | output | 2 | Size code passed to the handler |
| hdl_wdata | output | 64 | Write data, native order |
| hdl_rdata | input | 64 | Handler read data, native order, sampled in the request cycle |

## Verification
The handler strobes, index, offset and native write data depend on the request through logic alone. The bench therefore samples them in the request cycle, one nanosecond after driving the inputs and well before the next rising edge. The response passes through one register. Each request pushes its expected read data into a queue, and a monitor samples just after the following rising edge. At that point the monitor pops one entry per response and flags any cycle where rsp_valid and the queue's occupancy disagree.

// File: rtl/regacc_pkg.sv
package regacc_pkg;

    typedef enum logic [1:0] {
        RD_HANDLER = 2'd0,
        RD_ZERO    = 2'd1,
        RD_ONES    = 2'd2
    } rd_kind_e;

    typedef enum logic {
        WR_HANDLER = 1'b0,
        WR_IGNORE  = 1'b1
    } wr_kind_e;

    // bit positions inside region_t.widths
    localparam int W_B8  = 0;
    localparam int W_W32 = 1;
    localparam int W_D64 = 2;

    localparam logic [1:0] SZ_1B = 2'd0;
    localparam logic [1:0] SZ_2B = 2'd1;
    localparam logic [1:0] SZ_4B = 2'd2;
    localparam logic [1:0] SZ_8B = 2'd3;

    typedef struct packed {
        logic [31:0] base;
        logic [31:0] span;
        logic [2:0]  widths;
        rd_kind_e    rd;
        wr_kind_e    wr;
    } region_t;

    localparam int REGION_COUNT = 4;

    // table sorted by base, regions do not overlap
    function automatic region_t region_entry(int idx);
        region_t e;
        e = '0;
        case (idx)
            0: begin
                e.base = 32'h00; e.span = 32'h10; e.widths = 3'b111;
                e.rd = RD_HANDLER; e.wr = WR_HANDLER;
            end
            1: begin
                e.base = 32'h10; e.span = 32'h10; e.widths = 3'b010;
                e.rd = RD_ZERO; e.wr = WR_IGNORE;
            end
            2: begin
                e.base = 32'h40; e.span = 32'h20; e.widths = 3'b011;
                e.rd = RD_ONES; e.wr = WR_HANDLER;
            end
            3: begin
                e.base = 32'h80; e.span = 32'h40; e.widths = 3'b100;
                e.rd = RD_HANDLER; e.wr = WR_IGNORE;
            end
            default: e = '0;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/regacc_match.sv
module regacc_match
    import regacc_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int NUM_REG = REGION_COUNT,
    parameter int IDX_W   = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] offset,
    output logic              hit,
    output logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] rel_off,
    output region_t           entry
);

    logic [NUM_REG-1:0] hit_vec;
    logic [32:0]        off_x;

    assign off_x = {1'b0, 32'(offset)};

    for (genvar gi = 0; gi < NUM_REG; gi++) begin : g_cmp
        localparam region_t ENT = region_entry(gi);
        localparam logic [32:0] LO = {1'b0, ENT.base};
        localparam logic [32:0] HI = {1'b0, ENT.base} + {1'b0, ENT.span};
        assign hit_vec[gi] = (off_x >= LO) && (off_x < HI);
    end

    always_comb begin
        hit     = 1'b0;
        idx     = '0;
        entry   = '0;
        rel_off = '0;
        for (int i = 0; i < NUM_REG; i++) begin
            if (hit_vec[i] && !hit) begin
                hit     = 1'b1;
                idx     = IDX_W'(i);
                entry   = region_entry(i);
                rel_off = offset - ADDR_W'(entry.base);
            end
        end
    end

    AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec)); // R1

endmodule

// File: rtl/regacc_legal.sv
module regacc_legal
    import regacc_pkg::*;
(
    input  logic       hit,
    input  logic [2:0] widths,
    input  logic [1:0] size,
    input  logic [2:0] addr_lo,
    output logic       ok
);

    always_comb begin
        case (size)
            SZ_1B:   ok = hit && widths[W_B8];
            SZ_4B:   ok = hit && widths[W_W32] && (addr_lo[1:0] == 2'b00);
            SZ_8B:   ok = hit && widths[W_D64] && (addr_lo == 3'b000);
            default: ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/regacc_lanes.sv
module regacc_lanes #(
    parameter int LANES  = 8,
    parameter bit TO_BUS = 1'b0
) (
    input  logic [LANES*8-1:0] din,
    input  logic [1:0]         size,
    output logic [LANES*8-1:0] dout
);

    localparam int CW = $clog2(LANES + 1);

    logic [CW-1:0] count;
    assign count = CW'(32'd1 << size);

    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        if (!TO_BUS) begin : g_in
            localparam logic [CW-1:0] POS = CW'(gi);
            assign dout[gi*8 +: 8] = (POS < count) ? din[(LANES-1-gi)*8 +: 8] : 8'h00;
        end else begin : g_out
            localparam int          SRC  = LANES - 1 - gi;
            localparam logic [CW-1:0] POS = CW'(SRC);
            assign dout[gi*8 +: 8] = (POS < count) ? din[SRC*8 +: 8] : 8'h00;
        end
    end

endmodule

// File: rtl/regacc_decoder.sv
module regacc_decoder
    import regacc_pkg::*;
#(
    parameter int               ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] DEV_BASE = 16'h1000,
    parameter int               NUM_REG  = REGION_COUNT,
    localparam int              IDX_W    = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [63:0]       req_wdata,
    output logic              rsp_valid,
    output logic [63:0]       rsp_rdata,
    output logic              hdl_rd_en,
    output logic              hdl_wr_en,
    output logic [IDX_W-1:0]  hdl_idx,
    output logic [ADDR_W-1:0] hdl_off,
    output logic [1:0]        hdl_size,
    output logic [63:0]       hdl_wdata,
    input  logic [63:0]       hdl_rdata
);

    logic [ADDR_W-1:0] offset;
    logic              hit;
    region_t           entry;
    logic              legal;
    logic [63:0]       rd_native;
    logic [63:0]       rd_bus;

    assign offset = req_addr - DEV_BASE;

    regacc_match #(.ADDR_W(ADDR_W), .NUM_REG(NUM_REG), .IDX_W(IDX_W)) u_match (
        .clk     (clk),
        .rst     (rst),
        .offset  (offset),
        .hit     (hit),
        .idx     (hdl_idx),
        .rel_off (hdl_off),
        .entry   (entry)
    );

    regacc_legal u_legal (
        .hit     (hit),
        .widths  (entry.widths),
        .size    (req_size),
        .addr_lo (req_addr[2:0]),
        .ok      (legal)
    );

    regacc_lanes #(.LANES(8), .TO_BUS(1'b0)) u_wlanes (
        .din  (req_wdata),
        .size (req_size),
        .dout (hdl_wdata)
    );

    regacc_lanes #(.LANES(8), .TO_BUS(1'b1)) u_rlanes (
        .din  (rd_native),
        .size (req_size),
        .dout (rd_bus)
    );

    assign hdl_size  = req_size;
    assign hdl_rd_en = req_valid && !req_write && legal && (entry.rd == RD_HANDLER);
    assign hdl_wr_en = req_valid &&  req_write && legal && (entry.wr == WR_HANDLER);

    always_comb begin
        if (!legal) begin
            rd_native = '0;
        end else begin
            case (entry.rd)
                RD_ZERO: rd_native = '0;
                RD_ONES: rd_native = '1;
                default: rd_native = hdl_rdata;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= (req_valid && !req_write) ? rd_bus : 64'd0;
        end
    end

    AST_RSP_NEXT: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R13
    AST_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid); // R13
    AST_NO_HALFWORD: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_size == SZ_2B) |-> !(hdl_rd_en || hdl_wr_en)); // R5
    AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_size == SZ_4B && req_addr[1:0] != 2'b00) |-> !(hdl_rd_en || hdl_wr_en)); // R3
    AST_DWORD_ALIGN: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_size == SZ_8B && req_addr[2:0] != 3'b000) |-> !(hdl_rd_en || hdl_wr_en)); // R4
    AST_ILLEGAL_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && !legal) |=> (rsp_rdata == 64'd0)); // R6
    AST_WRITE_RSP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write) |=> (rsp_rdata == 64'd0)); // R7
    AST_BYTE_LANES_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_size == SZ_1B) |=> (rsp_rdata[55:0] == 56'd0)); // R9
    AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && hit && entry.wr == WR_IGNORE) |-> !hdl_wr_en); // R12

endmodule

// File: tb/sim_regacc_decoder.sv
module sim_regacc_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic        hdl_rd_en, hdl_wr_en;
    logic [1:0]  hdl_idx;
    logic [15:0] hdl_off;
    logic [1:0]  hdl_size;
    logic [63:0] hdl_wdata;
    logic [63:0] hdl_rdata = '0;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [63:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    regacc_decoder u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .hdl_rd_en(hdl_rd_en), .hdl_wr_en(hdl_wr_en), .hdl_idx(hdl_idx),
        .hdl_off(hdl_off), .hdl_size(hdl_size), .hdl_wdata(hdl_wdata),
        .hdl_rdata(hdl_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // region model taken from R1..R4, R10..R12
    function automatic int find_reg(logic [15:0] addr);
        logic [15:0] off;
        off = addr - 16'h1000;
        if (off < 16'h10) return 0;
        if (off < 16'h20) return 1;
        if (off >= 16'h40 && off < 16'h60) return 2;
        if (off >= 16'h80 && off < 16'hC0) return 3;
        return -1;
    endfunction

    function automatic logic [15:0] reg_base(int r);
        case (r)
            0: return 16'h00;
            1: return 16'h10;
            2: return 16'h40;
            default: return 16'h80;
        endcase
    endfunction

    function automatic bit is_legal(int r, logic [1:0] sz, logic [15:0] addr);
        bit b8, w32, d64;
        if (r < 0) return 1'b0;
        b8  = (r == 0 || r == 2);
        w32 = (r == 0 || r == 1 || r == 2);
        d64 = (r == 0 || r == 3);
        case (sz)
            2'd0: return b8;
            2'd2: return w32 && addr[1:0] == 2'b00;
            2'd3: return d64 && addr[2:0] == 3'b000;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [63:0] bus2nat(logic [63:0] bus, logic [1:0] sz);
        logic [63:0] v;
        int n;
        v = '0;
        n = 1 << sz;
        for (int k = 0; k < n; k++) v[8*k +: 8] = bus[56-8*k +: 8];
        return v;
    endfunction

    function automatic logic [63:0] nat2bus(logic [63:0] v, logic [1:0] sz);
        logic [63:0] b;
        int n;
        b = '0;
        n = 1 << sz;
        for (int k = 0; k < n; k++) b[56-8*k +: 8] = v[8*k +: 8];
        return b;
    endfunction

    task automatic access(input bit wr, input logic [15:0] addr, input logic [1:0] sz,
                          input logic [63:0] data, input string tag);
        int r;
        bit lg, e_rd, e_wr;
        logic [63:0] e_rdata;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = addr;
        req_size  = sz;
        req_wdata = wr ? data : 64'hA5A5_5A5A_C3C3_3C3C;
        hdl_rdata = wr ? 64'h0 : data;
        r  = find_reg(addr);
        lg = is_legal(r, sz, addr);
        e_rd = !wr && lg && (r == 0 || r == 3);
        e_wr =  wr && lg && (r == 0 || r == 2);
        if (wr || !lg || r == 1) e_rdata = 64'd0;
        else if (r == 2)         e_rdata = nat2bus(64'hFFFF_FFFF_FFFF_FFFF, sz);
        else                     e_rdata = nat2bus(data, sz);
        #1;
        chk(hdl_rd_en == e_rd, {tag, " rd_en"}, 64'(hdl_rd_en), 64'(e_rd));
        chk(hdl_wr_en == e_wr, {tag, " wr_en"}, 64'(hdl_wr_en), 64'(e_wr));
        if (e_wr) chk(hdl_wdata == bus2nat(data, sz), {tag, " R8 wdata"}, hdl_wdata, bus2nat(data, sz));
        if (e_rd || e_wr) begin
            chk(hdl_idx == 2'(r), {tag, " R1 idx"}, 64'(hdl_idx), 64'(r));
            chk(hdl_off == (addr - 16'h1000 - reg_base(r)), {tag, " R1 off"},
                64'(hdl_off), 64'(addr - 16'h1000 - reg_base(r)));
        end
        exp_q.push_back(e_rdata);
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // monitor: one response per request, due right after the next rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!rst) begin
                if (rsp_valid) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R13 unexpected rsp_valid", 64'd1, 64'd0);
                    end else begin
                        logic [63:0] e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        chk(rsp_rdata == e, {t, " rsp_rdata"}, rsp_rdata, e);
                    end
                end else if (exp_q.size() != 0) begin
                    chk(1'b0, "R13 missing rsp_valid", 64'd0, 64'd1);
                    void'(exp_q.pop_front());
                    void'(tag_q.pop_front());
                end
            end
        end
    end

    initial begin
        #200000;
        if (!finished) begin
            chk(1'b0, "watchdog expired", 64'd0, 64'd1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R13 reset rsp_valid", 64'(rsp_valid), 64'd0);
        chk(rsp_rdata == 64'd0, "R13 reset rsp_rdata", rsp_rdata, 64'd0);
        rst = 1'b0;

        // handler region 0, all widths
        access(1'b1, 16'h1000, 2'd3, 64'h1122_3344_5566_7788, "R8 R4 write 8B r0");
        access(1'b1, 16'h1008, 2'd2, 64'hAABB_CCDD_EEFF_0011, "R8 R3 write 4B r0");
        access(1'b0, 16'h1004, 2'd2, 64'hDEAD_BEEF_A1B2_C3D4, "R9 R3 read 4B r0");
        access(1'b0, 16'h1003, 2'd0, 64'h0102_0304_0506_0777, "R9 R2 read 1B r0");
        access(1'b0, 16'h1008, 2'd3, 64'h0F1E_2D3C_4B5A_6978, "R9 R4 read 8B r0");
        access(1'b0, 16'h100F, 2'd0, 64'h0000_0000_0000_00C5, "R1 last byte r0");
        idle();
        // 2-byte never legal
        access(1'b1, 16'h1000, 2'd1, 64'h1234_0000_0000_0000, "R5 write 2B r0");
        access(1'b0, 16'h1002, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, "R5 read 2B r0");
        // misalignment
        access(1'b1, 16'h1002, 2'd2, 64'h5555_5555_0000_0000, "R3 misaligned write");
        access(1'b0, 16'h1004, 2'd3, 64'h7777_7777_7777_7777, "R4 misaligned read r0");
        access(1'b0, 16'h1084, 2'd3, 64'h6666_6666_6666_6666, "R4 misaligned read r3");
        access(1'b0, 16'h1088, 2'd3, 64'h0123_4567_89AB_CDEF, "R4 R1 read 8B r3");
        // width flags per region
        access(1'b0, 16'h1014, 2'd0, 64'h9999_9999_9999_9999, "R2 byte read r1");
        access(1'b1, 16'h1081, 2'd0, 64'h4400_0000_0000_0000, "R2 byte write r3");
        access(1'b0, 16'h1090, 2'd2, 64'h3333_3333_3333_3333, "R3 word read r3");
        idle();
        // built-in kinds
        access(1'b0, 16'h1010, 2'd2, 64'h8888_8888_8888_8888, "R10 read zero r1");
        access(1'b1, 16'h1014, 2'd2, 64'h1111_2222_0000_0000, "R12 write r1");
        access(1'b1, 16'h10B8, 2'd3, 64'h1111_2222_3333_4444, "R12 write r3");
        access(1'b0, 16'h1044, 2'd2, 64'h0000_0000_0000_0000, "R11 read ones 4B");
        access(1'b0, 16'h105F, 2'd0, 64'h0000_0000_0000_0000, "R11 read ones 1B");
        access(1'b1, 16'h1047, 2'd0, 64'hBE00_0000_0000_0000, "R11 R8 write r2");
        access(1'b1, 16'h1058, 2'd2, 64'hCAFE_F00D_0000_0000, "R1 write r2 word");
        access(1'b0, 16'h1048, 2'd3, 64'h0, "R4 doubleword r2");
        // unmapped offsets
        access(1'b0, 16'h1020, 2'd2, 64'hABAB_ABAB_ABAB_ABAB, "R6 gap read");
        access(1'b1, 16'h1060, 2'd2, 64'hABAB_ABAB_0000_0000, "R7 gap write");
        access(1'b0, 16'h0FF8, 2'd3, 64'hCDCD_CDCD_CDCD_CDCD, "R6 below base read");
        access(1'b1, 16'h10C0, 2'd3, 64'hEFEF_EFEF_EFEF_EFEF, "R7 past end write");
        access(1'b0, 16'h10C0, 2'd0, 64'h1212_1212_1212_1212, "R6 past end read");
        idle();
        idle();
        access(1'b0, 16'h1000, 2'd3, 64'h8070_6050_4030_2010, "R13 after gap");
        idle();
        idle();
        idle();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule